// File: doc/BRIEF.md
# Bit-Vector Directory Coherence Controller

This block is the memory-side home agent for a group of `NPROC` processors that share `NBLK` memory blocks. Each block has a directory record: one presence flag per processor and a single exclusive flag. The block also holds the memory word for that block. A cache that misses sends a request to the controller. The request names the processor, the block, and whether the miss is a read or a write. The controller looks up the record and decides what must happen before the miss can be served. It may pull the line back from an exclusive holder, or it may invalidate the processors that share the line. It then grants the request with data and rewrites the record.

Messages to the caches are point-to-point. Each message goes only to a processor whose presence flag is set, and the controller never broadcasts. The controller serves one request at a time. A new request is held off with `req_ready` low until the current request has been granted, so requests to the same block are served in the order they were accepted. Invalidation acknowledgements are counted against the number of sharers that were sent invalidations.

Top module: `dir_ctrl`

## Requirements
- R1: After reset every record has no presence flags and a clear exclusive flag. Block b's memory word is 0xA5A50000 + b*0x101. `req_ready` is high, and `msg_valid` and `gnt_valid` are low.
- R2: A read miss to a block whose exclusive flag is clear sends no message. It is granted with the memory word, and the reader's presence flag is set.
- R3: A read miss to a block held exclusively by another processor sends exactly one message of kind 1 (downgrade recall) to that holder. The holder's data response is written to memory and returned in the grant. Afterwards the block is not exclusive, and both the former holder and the reader are present.
- R4: A write miss to a non-exclusive block sends one message of kind 3 (invalidate) to each present processor other than the writer. These go out one per cycle in ascending processor index. The write is granted with the memory word.
- R5: A write that needs invalidations is granted only after the number of acknowledgements received equals the number of invalidations sent. The acknowledgement count never exceeds that number.
- R6: After any granted write, the writer is the only present processor and the block is exclusive. A later miss by another processor therefore contacts only the writer.
- R7: A write miss to a block held exclusively by another processor sends one message of kind 2 (invalidating recall) to the holder. The returned data is written to memory and supplied in the grant.
- R8: A request from the processor that already holds the block exclusively is granted with the memory word. No message is sent and the record does not change.
- R9: `req_ready` is low from the cycle after a request is accepted until its grant has been issued. Grants are one-cycle pulses and come in acceptance order.
- R10: Every message goes to a processor whose presence flag is set for the addressed block. Responses are taken only while a request is waiting for them.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Miss request present |
| req_ready | output | 1 | Controller can accept a request |
| req_proc | input | $clog2(NPROC) | Requesting processor |
| req_write | input | 1 | 1 = write miss, 0 = read miss |
| req_blk | input | $clog2(NBLK) | Block index |
| msg_valid | output | 1 | Message to a cache this cycle |
| msg_kind | output | 2 | 1 downgrade recall, 2 invalidating recall, 3 invalidate |
| msg_dest | output | $clog2(NPROC) | Destination processor |
| msg_blk | output | $clog2(NBLK) | Block the message refers to |
| rsp_valid | input | 1 | Response from a cache |
| rsp_proc | input | $clog2(NPROC) | Responding processor |
| rsp_is_data | input | 1 | 1 = recall data, 0 = invalidation acknowledge |
| rsp_data | input | DATA_W | Recalled line data |
| gnt_valid | output | 1 | Grant pulse |
| gnt_proc | output | $clog2(NPROC) | Processor being granted |
| gnt_write | output | 1 | Grant is for a write |
| gnt_blk | output | $clog2(NBLK) | Granted block |
| gnt_data | output | DATA_W | Line data supplied with the grant |

## Verification
The assertions assume that caches answer only the messages they receive: one acknowledgement per invalidation, and one data response per recall, sent by the recalled holder. They also assume no processor issues a read miss for a block it already holds exclusively while the record says otherwise. The bench keeps to this because its responder replies only to messages seen on the message port, one reply per message and two cycles apart. Its requests come from a model that tracks the same records. Under these conditions the bound on the acknowledgement count and the single-holder invariant for exclusive blocks must both hold.

// File: rtl/dir_pkg.sv
package dir_pkg;

  typedef enum logic [1:0] {
    MSG_NONE         = 2'd0,
    MSG_RECALL_SHARE = 2'd1,
    MSG_RECALL_INV   = 2'd2,
    MSG_INVAL        = 2'd3
  } msg_kind_e;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_DECIDE,
    ST_SEND,
    ST_WAIT,
    ST_FINISH
  } dir_state_e;

  // number of set bits in a presence vector (zero-extended)
  function automatic int count_ones(input logic [63:0] v);
    int n = 0;
    for (int k = 0; k < 64; k++) n += int'(v[k]);
    return n;
  endfunction

  // index of the lowest set bit, 0 when none
  function automatic int lowest_set(input logic [63:0] v);
    int idx = 0;
    for (int k = 63; k >= 0; k--) if (v[k]) idx = k;
    return idx;
  endfunction

  // memory contents after reset
  function automatic logic [63:0] mem_seed(input int blk);
    return 64'hA5A5_0000 + 64'(blk) * 64'h101;
  endfunction

endpackage

// File: rtl/dir_entry_store.sv
module dir_entry_store #(
  parameter int NPROC  = 4,
  parameter int NBLK   = 8,
  parameter int DATA_W = 32,
  parameter int BW     = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [BW-1:0]     rd_blk,
  output logic [NPROC-1:0]  rd_pres,
  output logic              rd_dirty,
  output logic [DATA_W-1:0] rd_data,
  input  logic              ent_we,
  input  logic [BW-1:0]     ent_blk,
  input  logic [NPROC-1:0]  ent_pres,
  input  logic              ent_dirty,
  input  logic              dat_we,
  input  logic [BW-1:0]     dat_blk,
  input  logic [DATA_W-1:0] dat_wdata
);

  logic [NPROC-1:0]  pres_w  [NBLK];
  logic              dirty_w [NBLK];
  logic [DATA_W-1:0] data_w  [NBLK];

  for (genvar b = 0; b < NBLK; b++) begin : g_blk
    localparam logic [63:0] SEED = dir_pkg::mem_seed(b);
    logic [NPROC-1:0]  pres_q;
    logic              dirty_q;
    logic [DATA_W-1:0] data_q;

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        pres_q  <= '0;
        dirty_q <= 1'b0;
        data_q  <= SEED[DATA_W-1:0];
      end else begin
        if (ent_we && ent_blk == BW'(b)) begin
          pres_q  <= ent_pres;
          dirty_q <= ent_dirty;
        end
        if (dat_we && dat_blk == BW'(b)) data_q <= dat_wdata;
      end
    end

    assign pres_w[b]  = pres_q;
    assign dirty_w[b] = dirty_q;
    assign data_w[b]  = data_q;

    // an exclusive block has exactly one holder
    assert_owner_unique_R6: assert property (@(posedge clk) disable iff (!rst_n)
      dirty_q |-> ($countones(pres_q) == 1));
  end

  assign rd_pres  = pres_w[rd_blk];
  assign rd_dirty = dirty_w[rd_blk];
  assign rd_data  = data_w[rd_blk];

endmodule

// File: rtl/dir_msg_seq.sv
module dir_msg_seq
  import dir_pkg::*;
#(
  parameter int NPROC = 4,
  parameter int BW    = 3,
  parameter int PW    = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [NPROC-1:0] load_mask,
  input  msg_kind_e        load_kind,
  input  logic [BW-1:0]    load_blk,
  output logic             msg_valid,
  output logic [PW-1:0]    msg_dest,
  output msg_kind_e        msg_kind,
  output logic [BW-1:0]    msg_blk,
  output logic             seq_idle
);

  logic [NPROC-1:0] pending_q;
  msg_kind_e        kind_q;
  logic [BW-1:0]    blk_q;

  always_comb begin
    msg_valid = |pending_q;
    msg_dest  = PW'(lowest_set(64'(pending_q)));
    msg_kind  = msg_valid ? kind_q : MSG_NONE;
    msg_blk   = blk_q;
    seq_idle  = !msg_valid;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pending_q <= '0;
      kind_q    <= MSG_NONE;
      blk_q     <= '0;
    end else if (load) begin
      pending_q <= load_mask;
      kind_q    <= load_kind;
      blk_q     <= load_blk;
    end else if (msg_valid) begin
      pending_q <= pending_q & ~(NPROC'(1) << msg_dest);
    end
  end

  // consecutive messages walk the processor indices upward
  assert_dest_ascending_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (msg_valid && $past(msg_valid)) |-> (msg_dest > $past(msg_dest)));

endmodule

// File: rtl/dir_ack_ctr.sv
module dir_ack_ctr #(
  parameter int CW = 3
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clear,
  input  logic [CW-1:0] expect_n,
  input  logic          ack,
  output logic          all_acked
);

  logic [CW-1:0] count_q;
  logic [CW-1:0] expect_q;

  assign all_acked = (count_q == expect_q);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      count_q  <= '0;
      expect_q <= '0;
    end else if (clear) begin
      count_q  <= '0;
      expect_q <= expect_n;
    end else if (ack) begin
      count_q  <= count_q + CW'(1);
    end
  end

  assert_ack_no_overflow_R5: assert property (@(posedge clk) disable iff (!rst_n)
    count_q <= expect_q);

endmodule

// File: rtl/dir_ctrl.sv
module dir_ctrl
  import dir_pkg::*;
#(
  parameter int NPROC  = 4,
  parameter int NBLK   = 8,
  parameter int DATA_W = 32,
  localparam int PW    = $clog2(NPROC),
  localparam int BW    = $clog2(NBLK)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [PW-1:0]     req_proc,
  input  logic              req_write,
  input  logic [BW-1:0]     req_blk,
  output logic              msg_valid,
  output logic [1:0]        msg_kind,
  output logic [PW-1:0]     msg_dest,
  output logic [BW-1:0]     msg_blk,
  input  logic              rsp_valid,
  input  logic [PW-1:0]     rsp_proc,
  input  logic              rsp_is_data,
  input  logic [DATA_W-1:0] rsp_data,
  output logic              gnt_valid,
  output logic [PW-1:0]     gnt_proc,
  output logic              gnt_write,
  output logic [BW-1:0]     gnt_blk,
  output logic [DATA_W-1:0] gnt_data
);

  localparam int CW = $clog2(NPROC + 1);

  dir_state_e        st_q;
  logic [PW-1:0]     r_proc, r_owner;
  logic              r_write;
  logic [BW-1:0]     r_blk;
  logic              r_need_data, r_got_data;
  logic [DATA_W-1:0] r_data;
  logic [NPROC-1:0]  r_newpres;
  logic              r_newdirty;

  logic              gnt_valid_q, gnt_write_q;
  logic [PW-1:0]     gnt_proc_q;
  logic [BW-1:0]     gnt_blk_q;
  logic [DATA_W-1:0] gnt_data_q;

  logic [NPROC-1:0]  rd_pres;
  logic              rd_dirty;
  logic [DATA_W-1:0] rd_data;

  // named internal events
  logic ev_accept, ev_waiting, ev_data_in, ev_ack_in, ev_done, ev_finish;
  logic seq_idle, all_acked;
  msg_kind_e seq_kind_out;

  // decision for the request under lookup
  logic [NPROC-1:0] bit_i, sharers;
  logic [PW-1:0]    owner;
  dir_state_e       d_next;
  logic [NPROC-1:0] d_pres, d_mask;
  logic             d_dirty, d_need_data, d_load;
  msg_kind_e        d_kind;
  logic [CW-1:0]    d_ack_n;

  assign req_ready  = (st_q == ST_IDLE);
  assign ev_accept  = req_valid && req_ready;
  assign ev_waiting = (st_q == ST_SEND) || (st_q == ST_WAIT);
  assign ev_data_in = ev_waiting && rsp_valid && rsp_is_data && r_need_data && (rsp_proc == r_owner);
  assign ev_ack_in  = ev_waiting && rsp_valid && !rsp_is_data && !r_need_data;
  assign ev_done    = r_need_data ? r_got_data : all_acked;
  assign ev_finish  = (st_q == ST_FINISH);

  always_comb begin
    bit_i       = NPROC'(1) << r_proc;
    owner       = PW'(lowest_set(64'(rd_pres)));
    sharers     = rd_pres & ~bit_i;
    d_next      = ST_FINISH;
    d_pres      = rd_pres;
    d_dirty     = rd_dirty;
    d_need_data = 1'b0;
    d_load      = 1'b0;
    d_mask      = '0;
    d_kind      = MSG_NONE;
    d_ack_n     = '0;
    if (rd_dirty && owner == r_proc) begin
      d_next = ST_FINISH;                       // requester already holds it
    end else if (!r_write) begin
      d_pres  = rd_pres | bit_i;
      d_dirty = 1'b0;
      if (rd_dirty) begin
        d_load      = 1'b1;
        d_mask      = NPROC'(1) << owner;
        d_kind      = MSG_RECALL_SHARE;
        d_need_data = 1'b1;
        d_next      = ST_SEND;
      end
    end else begin
      d_pres  = bit_i;
      d_dirty = 1'b1;
      if (rd_dirty) begin
        d_load      = 1'b1;
        d_mask      = NPROC'(1) << owner;
        d_kind      = MSG_RECALL_INV;
        d_need_data = 1'b1;
        d_next      = ST_SEND;
      end else if (|sharers) begin
        d_load  = 1'b1;
        d_mask  = sharers;
        d_kind  = MSG_INVAL;
        d_ack_n = CW'(count_ones(64'(sharers)));
        d_next  = ST_SEND;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q        <= ST_IDLE;
      r_proc      <= '0;
      r_owner     <= '0;
      r_write     <= 1'b0;
      r_blk       <= '0;
      r_need_data <= 1'b0;
      r_got_data  <= 1'b0;
      r_data      <= '0;
      r_newpres   <= '0;
      r_newdirty  <= 1'b0;
      gnt_valid_q <= 1'b0;
      gnt_write_q <= 1'b0;
      gnt_proc_q  <= '0;
      gnt_blk_q   <= '0;
      gnt_data_q  <= '0;
    end else begin
      gnt_valid_q <= 1'b0;
      if (ev_data_in) begin
        r_got_data <= 1'b1;
        r_data     <= rsp_data;
      end
      unique case (st_q)
        ST_IDLE: if (ev_accept) begin
          r_proc  <= req_proc;
          r_write <= req_write;
          r_blk   <= req_blk;
          st_q    <= ST_DECIDE;
        end
        ST_DECIDE: begin
          r_newpres   <= d_pres;
          r_newdirty  <= d_dirty;
          r_need_data <= d_need_data;
          r_got_data  <= 1'b0;
          r_data      <= rd_data;
          r_owner     <= owner;
          st_q        <= d_next;
        end
        ST_SEND: if (seq_idle) st_q <= ST_WAIT;
        ST_WAIT: if (ev_done) st_q <= ST_FINISH;
        ST_FINISH: begin
          gnt_valid_q <= 1'b1;
          gnt_proc_q  <= r_proc;
          gnt_write_q <= r_write;
          gnt_blk_q   <= r_blk;
          gnt_data_q  <= r_data;
          st_q        <= ST_IDLE;
        end
        default: st_q <= ST_IDLE;
      endcase
    end
  end

  dir_entry_store #(.NPROC(NPROC), .NBLK(NBLK), .DATA_W(DATA_W), .BW(BW)) u_store (
    .clk, .rst_n,
    .rd_blk   (r_blk),
    .rd_pres  (rd_pres),
    .rd_dirty (rd_dirty),
    .rd_data  (rd_data),
    .ent_we   (ev_finish),
    .ent_blk  (r_blk),
    .ent_pres (r_newpres),
    .ent_dirty(r_newdirty),
    .dat_we   (ev_data_in),
    .dat_blk  (r_blk),
    .dat_wdata(rsp_data)
  );

  dir_msg_seq #(.NPROC(NPROC), .BW(BW), .PW(PW)) u_seq (
    .clk, .rst_n,
    .load     (st_q == ST_DECIDE && d_load),
    .load_mask(d_mask),
    .load_kind(d_kind),
    .load_blk (r_blk),
    .msg_valid(msg_valid),
    .msg_dest (msg_dest),
    .msg_kind (seq_kind_out),
    .msg_blk  (msg_blk),
    .seq_idle (seq_idle)
  );
  assign msg_kind = seq_kind_out;

  dir_ack_ctr #(.CW(CW)) u_ack (
    .clk, .rst_n,
    .clear    (st_q == ST_DECIDE),
    .expect_n (d_ack_n),
    .ack      (ev_ack_in),
    .all_acked(all_acked)
  );

  assign gnt_valid = gnt_valid_q;
  assign gnt_proc  = gnt_proc_q;
  assign gnt_write = gnt_write_q;
  assign gnt_blk   = gnt_blk_q;
  assign gnt_data  = gnt_data_q;

  assert_msg_only_busy_R9: assert property (@(posedge clk) disable iff (!rst_n)
    msg_valid |-> !req_ready);

  assert_no_broadcast_R10: assert property (@(posedge clk) disable iff (!rst_n)
    msg_valid |-> rd_pres[msg_dest]);

  assert_grant_after_acks_R5: assert property (@(posedge clk) disable iff (!rst_n)
    ev_finish |-> all_acked);

  assert_grant_pulse_R9: assert property (@(posedge clk) disable iff (!rst_n)
    gnt_valid |=> !gnt_valid);

endmodule

// File: tb/tb_dir_ctrl.sv
module tb_dir_ctrl;
  localparam int NP = 4, NB = 8, DW = 32;

  logic clk = 1'b0, rst_n = 1'b0;
  logic req_valid = 0, req_write = 0;
  logic [1:0] req_proc = '0;
  logic [2:0] req_blk = '0;
  logic req_ready, msg_valid, gnt_valid, gnt_write;
  logic [1:0] msg_kind, msg_dest, gnt_proc;
  logic [2:0] msg_blk, gnt_blk;
  logic [DW-1:0] gnt_data;
  logic rsp_valid = 0, rsp_is_data = 0;
  logic [1:0] rsp_proc = '0;
  logic [DW-1:0] rsp_data = '0;

  always #2 clk = ~clk;

  dir_ctrl #(.NPROC(NP), .NBLK(NB), .DATA_W(DW)) dut (.*);

  typedef struct packed { logic [1:0] kind; logic [1:0] dest; logic [2:0] blk; } msg_t;
  typedef struct packed { logic [1:0] proc; logic wr; logic [2:0] blk; logic [DW-1:0] data; } gnt_t;

  msg_t  exp_msg[$];  string exp_msg_tag[$];
  gnt_t  exp_gnt[$];  string exp_gnt_tag[$];  int exp_gnt_acks[$];
  msg_t  resp_q[$];   logic [DW-1:0] rec_data[$];

  logic [NP-1:0] m_pres[NB];
  logic          m_dirty[NB];
  logic [DW-1:0] m_mem[NB];
  logic [DW-1:0] m_cache[NP][NB];
  int acks_planned = 0, acks_sent = 0, op_no = 0;
  int n_chk = 0, n_fail = 0;
  bit finished = 0;

  task automatic check(input bit ok, input string tag, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
    end
  endtask

  function automatic int lowest(input logic [NP-1:0] v);
    for (int k = 0; k < NP; k++) if (v[k]) return k;
    return 0;
  endfunction

  // model of the requirements; pushes expected traffic, then issues the request
  task automatic do_req(input int p, input bit w, input int b, input string tag);
    int own;
    logic [DW-1:0] gd;
    own = lowest(m_pres[b]);
    op_no++;
    if (m_dirty[b] && own == p) begin
      gd = m_mem[b];                                        // R8
      if (w) m_cache[p][b] = 32'hC000_0000 | (op_no << 8) | (p << 4) | b;
    end else if (!w && !m_dirty[b]) begin
      gd = m_mem[b];
      m_pres[b][p] = 1'b1;
    end else if (!w) begin
      exp_msg.push_back('{kind: 2'd1, dest: 2'(own), blk: 3'(b)}); exp_msg_tag.push_back(tag);
      gd = m_cache[own][b]; rec_data.push_back(gd); m_mem[b] = gd;
      m_pres[b][p] = 1'b1; m_dirty[b] = 1'b0;
    end else begin
      if (m_dirty[b]) begin
        exp_msg.push_back('{kind: 2'd2, dest: 2'(own), blk: 3'(b)}); exp_msg_tag.push_back(tag);
        gd = m_cache[own][b]; rec_data.push_back(gd); m_mem[b] = gd;
      end else begin
        gd = m_mem[b];
        for (int q = 0; q < NP; q++)
          if (m_pres[b][q] && q != p) begin
            exp_msg.push_back('{kind: 2'd3, dest: 2'(q), blk: 3'(b)}); exp_msg_tag.push_back(tag);
            acks_planned++;
          end
      end
      m_pres[b] = '0; m_pres[b][p] = 1'b1; m_dirty[b] = 1'b1;
      m_cache[p][b] = 32'hC000_0000 | (op_no << 8) | (p << 4) | b;
    end
    exp_gnt.push_back('{proc: 2'(p), wr: w, blk: 3'(b), data: gd});
    exp_gnt_tag.push_back(tag); exp_gnt_acks.push_back(acks_planned);
    @(negedge clk);
    while (!req_ready) @(negedge clk);
    req_valid = 1'b1; req_proc = 2'(p); req_write = w; req_blk = 3'(b);
    @(negedge clk);
    req_valid = 1'b0;
    check(req_ready == 1'b0, "R9", "ready low after accept", 64'(req_ready), 64'd0);
  endtask

  // monitor: compare messages and grants
  initial begin
    forever begin
      @(negedge clk);
      if (rst_n && msg_valid) begin
        resp_q.push_back('{kind: msg_kind, dest: msg_dest, blk: msg_blk});
        if (exp_msg.size() == 0)
          check(1'b0, "R10", "unexpected message", 64'({msg_kind, msg_dest, msg_blk}), 64'd0);
        else begin
          msg_t e; string t;
          e = exp_msg.pop_front(); t = exp_msg_tag.pop_front();
          check({msg_kind, msg_dest, msg_blk} == e, t, "message kind/dest/blk",
                64'({msg_kind, msg_dest, msg_blk}), 64'(e));
        end
      end
      if (rst_n && gnt_valid) begin
        if (exp_gnt.size() == 0)
          check(1'b0, "R9", "unexpected grant", 64'(gnt_proc), 64'd0);
        else begin
          gnt_t g; string t; int a;
          g = exp_gnt.pop_front(); t = exp_gnt_tag.pop_front(); a = exp_gnt_acks.pop_front();
          check({gnt_proc, gnt_write, gnt_blk} == {g.proc, g.wr, g.blk}, t, "grant id",
                64'({gnt_proc, gnt_write, gnt_blk}), 64'({g.proc, g.wr, g.blk}));
          check(gnt_data == g.data, t, "grant data", 64'(gnt_data), 64'(g.data));
          check(acks_sent == a, "R5", "acks before grant", 64'(acks_sent), 64'(a));
        end
      end
    end
  end

  // cache responder: one reply per message, spaced two cycles apart
  initial begin
    int gap = 2;
    forever begin
      @(posedge clk); #1;
      rsp_valid = 1'b0;
      if (resp_q.size() > 0) begin
        if (gap > 0) gap--;
        else begin
          msg_t m;
          m = resp_q.pop_front();
          rsp_proc = m.dest;
          rsp_valid = 1'b1;
          if (m.kind == 2'd3) begin
            rsp_is_data = 1'b0; rsp_data = '0; acks_sent++;
          end else begin
            rsp_is_data = 1'b1; rsp_data = rec_data.pop_front();
          end
          gap = 2;
        end
      end
    end
  end

  task automatic summary();
    if (!finished) begin
      finished = 1;
      $display("  %0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    check(1'b0, "R9", "watchdog expired", 64'd0, 64'd1);
    summary();
  end

  initial begin
    for (int b = 0; b < NB; b++) begin
      m_pres[b] = '0; m_dirty[b] = 1'b0; m_mem[b] = 32'hA5A5_0000 + b * 32'h101;
      for (int q = 0; q < NP; q++) m_cache[q][b] = '0;
    end
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check(req_ready == 1'b1, "R1", "ready after reset", 64'(req_ready), 64'd1);
    check(msg_valid == 1'b0, "R1", "no message after reset", 64'(msg_valid), 64'd0);
    check(gnt_valid == 1'b0, "R1", "no grant after reset", 64'(gnt_valid), 64'd0);

    do_req(2, 0, 6, "R1");   // reset memory seed on a clean block
    do_req(0, 0, 0, "R2");
    do_req(1, 0, 0, "R2");
    do_req(2, 0, 0, "R2");
    do_req(1, 1, 0, "R4");   // invalidates 0 and 2
    do_req(3, 0, 0, "R3");   // downgrade recall from 1
    do_req(2, 1, 0, "R6");   // invalidates 1 and 3 only
    do_req(0, 1, 0, "R7");   // invalidating recall from 2
    do_req(0, 1, 0, "R8");   // owner writes again
    do_req(0, 0, 0, "R8");   // owner reads
    do_req(3, 0, 0, "R6");   // recall goes to 0 alone
    // back-to-back traffic over several blocks
    do_req(3, 1, 5, "R9");
    do_req(1, 0, 5, "R9");
    do_req(2, 0, 7, "R9");
    do_req(0, 1, 5, "R9");
    // all four share, then one writes
    for (int q = 0; q < NP; q++) do_req(q, 0, 2, "R2");
    do_req(3, 1, 2, "R5");
    do_req(1, 1, 2, "R7");

    while (exp_gnt.size() > 0) @(negedge clk);
    repeat (10) @(negedge clk);
    check(exp_msg.size() == 0, "R10", "messages left unsent", 64'(exp_msg.size()), 64'd0);
    check(resp_q.size() == 0, "R5", "responses left", 64'(resp_q.size()), 64'd0);
    check(req_ready == 1'b1, "R9", "ready when quiet", 64'(req_ready), 64'd1);
    summary();
  end
endmodule